// File: doc/BRIEF.md
# Lockable Configuration Store

This block keeps the configuration memory of a programmable logic device: a small bank of fuse words, one security bit and a 24-bit identification word. A device programmer drives it through a command interface made of a one-cycle valid strobe, a 3-bit opcode, a word address, write data for fuse words and write data for the identification word. The block answers reads with a one-cycle response and flags refused commands with a one-cycle error pulse.

Once the security bit is set, the fuse words can be neither read back nor rewritten. The only way to clear the bit is a bulk erase. A bulk erase returns every fuse word to the erased value, clears the security bit and wipes the identification word. The identification word can be written once per erase cycle. It can always be read back, including while the store is secured, so a locked part can still be identified. The bulk erase keeps the block busy for a fixed number of cycles, and any command that arrives during that window is dropped.

Top module: `cfg_lock_store`

## Requirements
- R1: During and after reset, every fuse word holds the erased value (all ones), the store is unsecured, the identification word is zero, and every output is low or zero.
- R2: An accepted program command (opcode 1) on an unsecured store writes the data into the addressed word. An accepted read command (opcode 2) on an unsecured store raises rd_valid for one cycle, with that word on rd_data, starting the cycle after the command.
- R3: An accepted secure command (opcode 4) sets the security bit. While the bit is set, a read raises rd_valid with rd_data all zeros and raises err for the same single cycle.
- R4: While the store is secured, a program command (opcode 1 or 7) leaves the array and the security bit unchanged and raises err for one cycle, starting the cycle after the command.
- R5: An accepted program-and-secure command (opcode 7) on an unsecured store writes the addressed word and sets the security bit in the same cycle.
- R6: An accepted bulk erase (opcode 3) sets every fuse word to all ones, clears the security bit and the identification word, and raises busy for exactly ERASE_CYCLES cycles, starting the cycle after the command. Nothing else clears the security bit.
- R7: A command presented while busy is high is ignored. It produces no response and no error, and it changes no state.
- R8: An identification write (opcode 5) stores the 24-bit value when no write has occurred since the last erase or reset. An identification read (opcode 6) raises sig_valid for one cycle with the stored word on sig_data, and it does so whether or not the store is secured.
- R9: A second identification write before an erase leaves the stored word unchanged and raises err for one cycle.
- R10: Opcode 0 and any cycle with cmd_valid low have no effect and produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 3 | Opcode: 0 none, 1 program, 2 read, 3 bulk erase, 4 secure, 5 identification write, 6 identification read, 7 program and secure |
| cmd_addr | input | ADDR_W | Fuse word address |
| cmd_wdata | input | DATA_W | Fuse word write data |
| cmd_sig | input | SIG_W | Identification word write data |
| busy | output | 1 | High while an erase is in progress |
| rd_valid | output | 1 | Fuse read response strobe |
| rd_data | output | DATA_W | Fuse read data, zero when refused or idle |
| sig_valid | output | 1 | Identification read response strobe |
| sig_data | output | SIG_W | Identification word, zero when idle |
| err | output | 1 | One-cycle pulse for a refused command |

## Verification
Every response, error pulse and state change takes effect at the first clock edge after the command is sampled, so each result is due exactly one cycle after its stimulus. An erase raises busy at that same edge and holds it for ERASE_CYCLES cycles. The bench drives each command at a falling edge and samples every output shortly after the following rising edge. It compares all outputs together against a reference model that is advanced by one step per cycle, and that model includes its own busy countdown. Effects on the array, on the lock and on the identification word are checked through later read commands issued through the normal command interface.

// File: rtl/cfg_lock_store.sv
module cfg_lock_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SIG_W = 24,
  parameter int ERASE_CYCLES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [SIG_W-1:0]  cmd_sig,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sig_valid,
  output logic [SIG_W-1:0]  sig_data,
  output logic              err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
  localparam logic [2:0] OP_PROG  = 3'd1;
  localparam logic [2:0] OP_READ  = 3'd2;
  localparam logic [2:0] OP_ERASE = 3'd3;
  localparam logic [2:0] OP_LOCK  = 3'd4;
  localparam logic [2:0] OP_SPROG = 3'd5;
  localparam logic [2:0] OP_SREAD = 3'd6;
  localparam logic [2:0] OP_PLOCK = 3'd7;

  logic [DATA_W-1:0] fuse [DEPTH];
  logic              sec;
  logic              sig_done;
  logic [SIG_W-1:0]  sig_word;
  logic [CNT_W-1:0]  cnt;
  logic              go;

  assign busy = (cnt != '0);
  assign go   = cmd_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) fuse[i] <= '1;
      sec       <= 1'b0;
      sig_done  <= 1'b0;
      sig_word  <= '0;
      cnt       <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      sig_valid <= 1'b0;
      sig_data  <= '0;
      err       <= 1'b0;
    end else begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      sig_valid <= 1'b0;
      sig_data  <= '0;
      err       <= 1'b0;
      if (busy) cnt <= cnt - CNT_W'(1);
      if (go) begin
        case (cmd_op)
          OP_PROG, OP_PLOCK: begin
            if (sec) err <= 1'b1;
            else begin
              fuse[cmd_addr] <= cmd_wdata;
              if (cmd_op == OP_PLOCK) sec <= 1'b1;
            end
          end
          OP_READ: begin
            rd_valid <= 1'b1;
            if (sec) err <= 1'b1;
            else rd_data <= fuse[cmd_addr];
          end
          OP_ERASE: begin
            for (int i = 0; i < DEPTH; i++) fuse[i] <= '1;
            sec      <= 1'b0;
            sig_done <= 1'b0;
            sig_word <= '0;
            cnt      <= CNT_W'(ERASE_CYCLES);
          end
          OP_LOCK: sec <= 1'b1;
          OP_SPROG: begin
            if (sig_done) err <= 1'b1;
            else begin
              sig_word <= cmd_sig;
              sig_done <= 1'b1;
            end
          end
          OP_SREAD: begin
            sig_valid <= 1'b1;
            sig_data  <= sig_word;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module cfg_lock_store_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic              busy,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              sig_valid,
  input logic              err,
  input logic              sec
);
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (!rd_valid && !sig_valid && !err));
  assert_blocked_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && err) |-> (rd_data == '0));
  assert_locked_read_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd2 && sec) |=> (rd_valid && err));
  assert_locked_prog_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd1 && sec) |=> (err && sec));
  assert_plock_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd7) |=> sec);
  assert_erase_unlocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd3) |=> (busy && !sec));
  assert_sec_clear_only_erase_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec) |-> $past(cmd_valid && !busy && cmd_op == 3'd3));
  assert_sig_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_op == 3'd6) |=> (sig_valid && !err && !rd_valid));
endmodule

bind cfg_lock_store cfg_lock_store_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
  .sig_valid(sig_valid), .err(err), .sec(sec)
);

// File: tb/tb_cfg_lock_store.sv
`timescale 1ns/1ps
module tb_cfg_lock_store;
  localparam int AW = 4, DW = 8, SW = 24, EC = 12;
  localparam int DEPTH = 1 << AW;
  localparam int VW = 3 + DW + SW + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic [SW-1:0] cmd_sig = '0;
  logic busy, rd_valid, sig_valid, err;
  logic [DW-1:0] rd_data;
  logic [SW-1:0] sig_data;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] m_fuse [DEPTH];
  logic m_sec, m_sdone;
  logic [SW-1:0] m_sig;
  int m_cnt;

  always #2 clk = ~clk;

  cfg_lock_store #(.ADDR_W(AW), .DATA_W(DW), .SIG_W(SW), .ERASE_CYCLES(EC)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_sig(cmd_sig),
    .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .sig_valid(sig_valid), .sig_data(sig_data), .err(err));

  function automatic logic [VW-1:0] pack_out(logic b, logic rv, logic [DW-1:0] rd,
                                             logic sv, logic [SW-1:0] sd, logic e);
    return {b, rv, rd, sv, sd, e};
  endfunction

  task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (busy,rd_valid,rd_data,sig_valid,sig_data,err)", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) m_fuse[i] = '1;
    m_sec = 1'b0; m_sdone = 1'b0; m_sig = '0; m_cnt = 0;
  endtask

  task automatic step(input logic v, input logic [2:0] op, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [SW-1:0] s);
    logic acc, rv, sv, e;
    logic [DW-1:0] rd;
    logic [SW-1:0] sd;
    string tag;
    @(negedge clk);
    cmd_valid = v; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_sig = s;
    @(posedge clk);
    #1;
    acc = v && (m_cnt == 0);
    rv = 1'b0; sv = 1'b0; e = 1'b0; rd = '0; sd = '0;
    tag = acc ? "R10" : (v ? "R7" : "R10");
    if (m_cnt > 0) m_cnt--;
    if (acc) begin
      case (op)
        3'd1: begin tag = m_sec ? "R4" : "R2"; if (m_sec) e = 1'b1; else m_fuse[a] = d; end
        3'd7: begin tag = m_sec ? "R4" : "R5"; if (m_sec) e = 1'b1; else begin m_fuse[a] = d; m_sec = 1'b1; end end
        3'd2: begin tag = m_sec ? "R3" : "R2"; rv = 1'b1; if (m_sec) e = 1'b1; else rd = m_fuse[a]; end
        3'd3: begin tag = "R6"; for (int i = 0; i < DEPTH; i++) m_fuse[i] = '1;
                m_sec = 1'b0; m_sdone = 1'b0; m_sig = '0; m_cnt = EC; end
        3'd4: begin tag = "R3"; m_sec = 1'b1; end
        3'd5: begin tag = m_sdone ? "R9" : "R8"; if (m_sdone) e = 1'b1; else begin m_sig = s; m_sdone = 1'b1; end end
        3'd6: begin tag = "R8"; sv = 1'b1; sd = m_sig; end
        default: ;
      endcase
    end
    check(tag, pack_out(busy, rd_valid, rd_data, sig_valid, sig_data, err),
          pack_out(m_cnt != 0, rv, rd, sv, sd, e));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, '0, '0);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20517));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1", pack_out(busy, rd_valid, rd_data, sig_valid, sig_data, err), '0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) step(1'b1, 3'd2, AW'(i), '0, '0);
    step(1'b1, 3'd6, '0, '0, '0);
    step(1'b1, 3'd0, 4'd3, 8'h12, '0);
    step(1'b1, 3'd1, 4'd3, 8'h5a, '0);
    step(1'b1, 3'd1, 4'd15, 8'h00, '0);
    step(1'b1, 3'd2, 4'd3, '0, '0);
    step(1'b1, 3'd2, 4'd15, '0, '0);
    step(1'b1, 3'd5, '0, '0, 24'hc0ffee);
    step(1'b1, 3'd5, '0, '0, 24'h123456);
    step(1'b1, 3'd6, '0, '0, '0);
    step(1'b1, 3'd4, '0, '0, '0);
    step(1'b1, 3'd2, 4'd3, '0, '0);
    step(1'b1, 3'd1, 4'd3, 8'h77, '0);
    step(1'b1, 3'd7, 4'd4, 8'h77, '0);
    step(1'b1, 3'd6, '0, '0, '0);
    step(1'b1, 3'd4, '0, '0, '0);
    step(1'b1, 3'd3, '0, '0, '0);
    step(1'b1, 3'd1, 4'd3, 8'haa, '0);
    step(1'b1, 3'd4, '0, '0, '0);
    step(1'b1, 3'd6, '0, '0, '0);
    idle(EC);
    step(1'b1, 3'd2, 4'd3, '0, '0);
    step(1'b1, 3'd6, '0, '0, '0);
    step(1'b1, 3'd7, 4'd9, 8'h3c, '0);
    step(1'b1, 3'd2, 4'd9, '0, '0);
    step(1'b1, 3'd3, '0, '0, '0);
    idle(EC);
    step(1'b1, 3'd2, 4'd9, '0, '0);
    step(1'b1, 3'd5, '0, '0, 24'habcdef);
    for (int k = 0; k < 4000; k++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      if (op == 3'd3 && $urandom_range(0, 7) != 0) op = 3'd2;
      if ((op == 3'd4 || op == 3'd7) && $urandom_range(0, 1) != 0) op = 3'd1;
      step($urandom_range(0, 5) != 0, op, AW'($urandom), DW'($urandom), SW'($urandom));
    end
    for (int i = 0; i < DEPTH; i++) step(1'b1, 3'd2, AW'(i), '0, '0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule